// File: doc/BRIEF.md
# Halfword signed multiply-accumulate unit

This execute-stage block takes one 32-bit instruction word per cycle and decodes it as a signed halfword multiply-accumulate in either of two forms. The compact form is a pair of 16-bit halfwords, with the first one in bits [31:16]. The conditional form is a single 32-bit word. The `in_compact` input says which form is present. The register file sits outside the block. The caller supplies the values of the two multiplicand registers and of the accumulator register. The block returns the decoded register indices, the 32-bit result and a write enable. One cycle after an accepted input, it also reports whether the word matched and whether the encoding is unpredictable.

For each multiplicand, a select bit picks the upper or lower signed 16-bit half. The two halves are multiplied. The 32-bit product is added to the accumulate value, and the sum wraps at 32 bits. A sticky saturation flag `q_flag` records any signed overflow of that addition. Only the synchronous `q_clear` input lowers it. In the compact form, an accumulator index of 15 turns the operation into a plain multiply. The condition field of the conditional form is passed through without being evaluated.

A two-state controller sequences the output. In `ST_IDLE` no result is presented. The transition `IDLE_TO_EMIT` fires on `in_valid`. In `ST_EMIT` the registered result is on the outputs with `out_valid` high. `EMIT_TO_EMIT` fires when another input arrives in that cycle, and `EMIT_TO_IDLE` fires when none does. Reset forces `ST_IDLE`.

Top module: `hmac_unit`

## Requirements
- R1: With `in_compact`=1, a word matches when bits [31:20] are 12'hFB1 and bits [7:6] are 2'b00. The fields are: first multiplicand index [19:16], accumulator index [15:12], destination index [11:8], first select [5], second select [4] and second multiplicand index [3:0].
- R2: With `in_compact`=0, a word matches when bits [27:20] are 8'h10, bit [7] is 1 and bit [4] is 0. The fields are: condition [31:28], destination [19:16], accumulator [15:12], second multiplicand index [11:8], second select [6], first select [5] and first multiplicand index [3:0]. `out_cond` carries the condition field; for the compact form it is 4'hE.
- R3: A select bit of 0 takes bits [15:0] of its operand, and a select bit of 1 takes bits [31:16]. The chosen half is treated as signed, and the unchosen half has no effect on the result.
- R4: The result is the signed 32-bit product plus `in_val_acc`, wrapped to 32 bits and never saturated.
- R5: In the compact form, an accumulator index of 15 gives `out_acc_used`=0 and a result equal to the product alone. `q_flag` is not set by that operation.
- R6: `q_flag` is set when both addends have the same sign and the sum has the other sign. Once set, it stays set through later operations without overflow.
- R7: `q_flag` is cleared one cycle after `q_clear` is high. If an overflow and `q_clear` fall in the same cycle, the flag ends up set.
- R8: A compact word is unpredictable if its destination or either multiplicand index is 13 or 15, or if its accumulator index is 13. When that happens, `out_unpred`=1 and `out_wr_en`=0, and `q_flag` does not change.
- R9: A conditional word is unpredictable if any of its four register indices is 15. When that happens, `out_unpred`=1 and `out_wr_en`=0, and `q_flag` does not change.
- R10: A word that does not match gives `out_match`=0 and `out_wr_en`=0, and leaves `q_flag` unchanged.
- R11: The outputs appear one cycle after `in_valid` and are registered, and back-to-back inputs give back-to-back results. Reset gives `out_valid`=0, `out_wr_en`=0 and `q_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operand values present this cycle |
| in_compact | input | 1 | 1: compact halfword-pair form, 0: conditional form |
| in_instr | input | 32 | Instruction word |
| in_val_n | input | 32 | Value of the first multiplicand register |
| in_val_m | input | 32 | Value of the second multiplicand register |
| in_val_acc | input | 32 | Value of the accumulator register |
| q_clear | input | 1 | Synchronous clear of the sticky flag |
| out_valid | output | 1 | Result presented this cycle |
| out_match | output | 1 | Word matched the selected form |
| out_unpred | output | 1 | Matched word has an unpredictable register choice |
| out_wr_en | output | 1 | Destination write enable |
| out_acc_used | output | 1 | Accumulate operand took part |
| out_cond | output | 4 | Condition field passed through |
| out_dst_idx | output | 4 | Destination register index |
| out_n_idx | output | 4 | First multiplicand register index |
| out_m_idx | output | 4 | Second multiplicand register index |
| out_acc_idx | output | 4 | Accumulator register index |
| out_result | output | 32 | Wrapped multiply-accumulate result |
| q_flag | output | 1 | Sticky accumulate-overflow flag |

## Verification
The assertions assume that `in_valid` is a clean level sampled at the clock edge. They also assume that `q_clear` is the only outside influence on the flag, so any rise of the flag must come from a written, accumulating result. The bench changes inputs only on the falling edge and keeps `in_valid` low while it pulses `q_clear`, except in the one directed case where the two are meant to coincide. It pairs each instruction word with the `in_compact` value of its form, except in the deliberate cross-form case, which must not match.

// File: rtl/hmac_pkg.sv
package hmac_pkg;

    localparam int INSN_W = 32;
    localparam int IDX_W  = 4;
    localparam int COND_W = 4;

    localparam logic [11:0]       CMP_OPCODE  = 12'hFB1;
    localparam logic [7:0]        CND_OPCODE  = 8'h10;
    localparam logic [IDX_W-1:0]  IDX_PC      = 4'd15;
    localparam logic [IDX_W-1:0]  IDX_SP      = 4'd13;
    localparam logic [COND_W-1:0] COND_ALWAYS = 4'hE;

    typedef struct packed {
        logic              match;
        logic              unpred;
        logic              acc_used;
        logic              sel_n_hi;
        logic              sel_m_hi;
        logic [COND_W-1:0] cond;
        logic [IDX_W-1:0]  dst;
        logic [IDX_W-1:0]  n_idx;
        logic [IDX_W-1:0]  m_idx;
        logic [IDX_W-1:0]  acc_idx;
    } dec_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } st_t;

endpackage

// File: rtl/hmac_decode.sv
module hmac_decode
    import hmac_pkg::*;
(
    input  logic              in_compact,
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);

    function automatic logic hi_reg(input logic [IDX_W-1:0] idx);
        return (idx == IDX_SP) || (idx == IDX_PC);
    endfunction

    dec_t cmp_d;
    dec_t cnd_d;

    // compact halfword-pair form
    always_comb begin
        cmp_d          = '0;
        cmp_d.match    = (insn[31:20] == CMP_OPCODE) && (insn[7:6] == 2'b00);
        cmp_d.cond     = COND_ALWAYS;
        cmp_d.n_idx    = insn[19:16];
        cmp_d.acc_idx  = insn[15:12];
        cmp_d.dst      = insn[11:8];
        cmp_d.sel_n_hi = insn[5];
        cmp_d.sel_m_hi = insn[4];
        cmp_d.m_idx    = insn[3:0];
        cmp_d.acc_used = (insn[15:12] != IDX_PC);
        cmp_d.unpred   = cmp_d.match &&
                         (hi_reg(cmp_d.dst) || hi_reg(cmp_d.n_idx) ||
                          hi_reg(cmp_d.m_idx) || (cmp_d.acc_idx == IDX_SP));
    end

    // conditional 32-bit form
    always_comb begin
        cnd_d          = '0;
        cnd_d.match    = (insn[27:20] == CND_OPCODE) && insn[7] && !insn[4];
        cnd_d.cond     = insn[31:28];
        cnd_d.dst      = insn[19:16];
        cnd_d.acc_idx  = insn[15:12];
        cnd_d.m_idx    = insn[11:8];
        cnd_d.sel_m_hi = insn[6];
        cnd_d.sel_n_hi = insn[5];
        cnd_d.n_idx    = insn[3:0];
        cnd_d.acc_used = 1'b1;
        cnd_d.unpred   = cnd_d.match &&
                         ((cnd_d.dst == IDX_PC) || (cnd_d.n_idx == IDX_PC) ||
                          (cnd_d.m_idx == IDX_PC) || (cnd_d.acc_idx == IDX_PC));
    end

    always_comb begin
        dec = in_compact ? cmp_d : cnd_d;
    end

endmodule

// File: rtl/hmac_half_pick.sv
module hmac_half_pick #(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] word,
    input  logic                take_hi,
    output logic [HALF_W-1:0]   half
);

    always_comb begin
        half = take_hi ? word[2*HALF_W-1:HALF_W] : word[HALF_W-1:0];
    end

endmodule

// File: rtl/hmac_mac.sv
module hmac_mac #(
    parameter int HALF_W = 16
) (
    input  logic                sel_n_hi,
    input  logic                sel_m_hi,
    input  logic                acc_used,
    input  logic [2*HALF_W-1:0] val_n,
    input  logic [2*HALF_W-1:0] val_m,
    input  logic [2*HALF_W-1:0] val_acc,
    output logic [2*HALF_W-1:0] result,
    output logic                ovf
);

    localparam int WORD_W = 2 * HALF_W;
    localparam int N_OPS  = 2;
    localparam int MSB    = WORD_W - 1;

    logic [WORD_W-1:0] ops  [N_OPS];
    logic              sels [N_OPS];
    logic [HALF_W-1:0] hv   [N_OPS];

    always_comb begin
        ops[0]  = val_n;
        ops[1]  = val_m;
        sels[0] = sel_n_hi;
        sels[1] = sel_m_hi;
    end

    for (genvar g = 0; g < N_OPS; g++) begin : g_pick
        hmac_half_pick #(.HALF_W(HALF_W)) u_pick (
            .word    (ops[g]),
            .take_hi (sels[g]),
            .half    (hv[g])
        );
    end

    logic signed [WORD_W-1:0] ext_n;
    logic signed [WORD_W-1:0] ext_m;
    logic        [WORD_W-1:0] prod;
    logic        [WORD_W-1:0] addend;
    logic        [WORD_W-1:0] sum;

    always_comb begin
        ext_n  = $signed({{HALF_W{hv[0][HALF_W-1]}}, hv[0]});
        ext_m  = $signed({{HALF_W{hv[1][HALF_W-1]}}, hv[1]});
        prod   = WORD_W'(ext_n * ext_m);
        addend = acc_used ? val_acc : '0;
        sum    = prod + addend;
        result = sum;
        ovf    = acc_used && (prod[MSB] == addend[MSB]) && (sum[MSB] != prod[MSB]);
    end

endmodule

// File: rtl/hmac_unit.sv
module hmac_unit
    import hmac_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                in_compact,
    input  logic [INSN_W-1:0]   in_instr,
    input  logic [2*HALF_W-1:0] in_val_n,
    input  logic [2*HALF_W-1:0] in_val_m,
    input  logic [2*HALF_W-1:0] in_val_acc,
    input  logic                q_clear,
    output logic                out_valid,
    output logic                out_match,
    output logic                out_unpred,
    output logic                out_wr_en,
    output logic                out_acc_used,
    output logic [COND_W-1:0]   out_cond,
    output logic [IDX_W-1:0]    out_dst_idx,
    output logic [IDX_W-1:0]    out_n_idx,
    output logic [IDX_W-1:0]    out_m_idx,
    output logic [IDX_W-1:0]    out_acc_idx,
    output logic [2*HALF_W-1:0] out_result,
    output logic                q_flag
);

    localparam int WORD_W = 2 * HALF_W;

    dec_t              dec;
    logic [WORD_W-1:0] mac_res;
    logic              mac_ovf;
    logic              take_write;
    logic              q_set;

    hmac_decode u_dec (
        .in_compact (in_compact),
        .insn       (in_instr),
        .dec        (dec)
    );

    hmac_mac #(.HALF_W(HALF_W)) u_mac (
        .sel_n_hi (dec.sel_n_hi),
        .sel_m_hi (dec.sel_m_hi),
        .acc_used (dec.acc_used),
        .val_n    (in_val_n),
        .val_m    (in_val_m),
        .val_acc  (in_val_acc),
        .result   (mac_res),
        .ovf      (mac_ovf)
    );

    st_t state;
    st_t state_nx;

    always_comb begin
        take_write = in_valid && dec.match && !dec.unpred;
        q_set      = take_write && mac_ovf;
    end

    // next state: IDLE_TO_EMIT, EMIT_TO_EMIT, EMIT_TO_IDLE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nx = in_valid ? ST_EMIT : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_match    <= 1'b0;
            out_unpred   <= 1'b0;
            out_wr_en    <= 1'b0;
            out_acc_used <= 1'b0;
            out_cond     <= '0;
            out_dst_idx  <= '0;
            out_n_idx    <= '0;
            out_m_idx    <= '0;
            out_acc_idx  <= '0;
            out_result   <= '0;
            q_flag       <= 1'b0;
        end else begin
            out_wr_en <= take_write;
            if (in_valid) begin
                out_match    <= dec.match;
                out_unpred   <= dec.unpred;
                out_acc_used <= dec.acc_used;
                out_cond     <= dec.cond;
                out_dst_idx  <= dec.dst;
                out_n_idx    <= dec.n_idx;
                out_m_idx    <= dec.m_idx;
                out_acc_idx  <= dec.acc_idx;
                out_result   <= mac_res;
            end
            if (q_set)        q_flag <= 1'b1;
            else if (q_clear) q_flag <= 1'b0;
        end
    end

    assign out_valid = (state == ST_EMIT);

    AST_WE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_wr_en |-> (out_valid && out_match && !out_unpred)); // R10

    AST_Q_HOLD: assert property (@(posedge clk) disable iff (rst)
        (q_flag && !q_clear) |=> q_flag); // R6

    AST_Q_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(q_flag) |-> (out_valid && out_wr_en && out_acc_used)); // R5

    AST_Q_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(q_flag) |-> $past(q_clear)); // R7

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R11

endmodule

// File: tb/hmac_unit_test.sv
`timescale 1ns/1ps
module hmac_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_compact;
    logic [31:0] in_instr;
    logic [31:0] in_val_n;
    logic [31:0] in_val_m;
    logic [31:0] in_val_acc;
    logic        q_clear;
    logic        out_valid;
    logic        out_match;
    logic        out_unpred;
    logic        out_wr_en;
    logic        out_acc_used;
    logic [3:0]  out_cond;
    logic [3:0]  out_dst_idx;
    logic [3:0]  out_n_idx;
    logic [3:0]  out_m_idx;
    logic [3:0]  out_acc_idx;
    logic [31:0] out_result;
    logic        q_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    hmac_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_compact(in_compact),
        .in_instr(in_instr), .in_val_n(in_val_n), .in_val_m(in_val_m),
        .in_val_acc(in_val_acc), .q_clear(q_clear), .out_valid(out_valid),
        .out_match(out_match), .out_unpred(out_unpred), .out_wr_en(out_wr_en),
        .out_acc_used(out_acc_used), .out_cond(out_cond), .out_dst_idx(out_dst_idx),
        .out_n_idx(out_n_idx), .out_m_idx(out_m_idx), .out_acc_idx(out_acc_idx),
        .out_result(out_result), .q_flag(q_flag)
    );

    typedef struct packed {
        logic        cmp;
        logic [31:0] insn;
        logic [31:0] vn;
        logic [31:0] vm;
        logic [31:0] va;
        logic [31:0] res;
        logic [3:0]  dst;
        logic [3:0]  cond;
        logic        match;
        logic        unpred;
        logic        we;
        logic        acc;
        logic        q;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'hFB11_2304, 32'h1234_0003, 32'h7777_0005, 32'h0000_0010, 32'h0000_001F, 4'd3, 4'hE, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b1, 32'hFB11_2334, 32'hFFFE_0000, 32'h0003_1111, 32'h0000_0064, 32'h0000_005E, 4'd3, 4'hE, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b1, 32'hFB11_2324, 32'h8000_0000, 32'h0000_8000, 32'h4000_0000, 32'h8000_0000, 4'd3, 4'hE, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        '{1'b1, 32'hFB11_F304, 32'h0000_0100, 32'h0000_0100, 32'h7FFF_FFFF, 32'h0001_0000, 4'd3, 4'hE, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 32'h0105_67A8, 32'h0007_0000, 32'hABCD_FFFF, 32'h0000_0007, 32'h0000_0000, 4'd5, 4'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b0, 32'hE101_23C4, 32'hDEAD_0002, 32'h0004_BEEF, 32'hFFFF_FFF0, 32'hFFFF_FFF8, 4'd1, 4'hE, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b0, 32'hE101_2384, 32'h0000_8000, 32'h0000_7FFF, 32'h8000_0000, 32'h4000_8000, 4'd1, 4'hE, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        '{1'b1, 32'hFB11_2D24, 32'h8000_0000, 32'h0000_8000, 32'h4000_0000, 32'h0000_0000, 4'd13, 4'hE, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b1, 32'hFB11_D304, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 4'd3, 4'hE, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b1, 32'hFB1F_2304, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 4'd3, 4'hE, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b0, 32'hE101_238F, 32'h0000_8000, 32'h0000_7FFF, 32'h8000_0000, 32'h0000_0000, 4'd1, 4'hE, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b1, 32'hFB11_2344, 32'h8000_0000, 32'h0000_8000, 32'h4000_0000, 32'h0000_0000, 4'd0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 32'hE101_2394, 32'h0000_8000, 32'h0000_7FFF, 32'h8000_0000, 32'h0000_0000, 4'd0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 32'hE101_2384, 32'h0000_8000, 32'h0000_7FFF, 32'h8000_0000, 32'h0000_0000, 4'd0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:       return "R1 compact low halves";
            1:       return "R3 compact high halves";
            2:       return "R6 compact positive overflow";
            3:       return "R5 multiply-only";
            4:       return "R2 conditional cond=0";
            5:       return "R4 conditional negative acc";
            6:       return "R6 conditional negative overflow";
            7:       return "R8 compact dst=13";
            8:       return "R8 compact acc=13";
            9:       return "R8 compact n=15";
            10:      return "R9 conditional n=15";
            11:      return "R10 compact bad bits";
            12:      return "R10 conditional bad bit4";
            default: return "R10 cross-form word";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one operation for one cycle; returns at the negedge after the capturing edge
    task automatic run_op(input logic cmp, input logic [31:0] insn, input logic [31:0] vn,
                          input logic [31:0] vm, input logic [31:0] va, input logic clr);
        @(negedge clk);
        in_compact = cmp; in_instr = insn; in_val_n = vn; in_val_m = vm; in_val_acc = va;
        q_clear = clr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; q_clear = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        q_clear = 1'b1;
        @(negedge clk);
        q_clear = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_compact = 1'b0; in_instr = '0;
        in_val_n = '0; in_val_m = '0; in_val_acc = '0; q_clear = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset out_valid", 32'(out_valid), 32'd0);
        check("R11 reset wr_en", 32'(out_wr_en), 32'd0);
        check("R11 reset q_flag", 32'(q_flag), 32'd0);

        for (int i = 0; i < NV; i++) begin
            pulse_clear();
            run_op(VECS[i].cmp, VECS[i].insn, VECS[i].vn, VECS[i].vm, VECS[i].va, 1'b0);
            check(vec_tag(i), 32'(out_valid), 32'd1);
            check(vec_tag(i), 32'(out_match), 32'(VECS[i].match));
            check(vec_tag(i), 32'(out_wr_en), 32'(VECS[i].we));
            check(vec_tag(i), 32'(q_flag), 32'(VECS[i].q));
            if (VECS[i].match) begin
                check(vec_tag(i), 32'(out_unpred), 32'(VECS[i].unpred));
                check(vec_tag(i), 32'(out_dst_idx), 32'(VECS[i].dst));
                check(vec_tag(i), 32'(out_cond), 32'(VECS[i].cond));
                check(vec_tag(i), 32'(out_acc_used), 32'(VECS[i].acc));
            end
            if (VECS[i].we) check(vec_tag(i), out_result, VECS[i].res);
        end

        // R1 and R2 index fields
        run_op(1'b1, 32'hFB15_6704, 32'h1, 32'h1, 32'h0, 1'b0);
        check("R1 n index", 32'(out_n_idx), 32'd5);
        check("R1 acc index", 32'(out_acc_idx), 32'd6);
        check("R1 m index", 32'(out_m_idx), 32'd4);
        run_op(1'b0, 32'h1109_AB82, 32'h1, 32'h1, 32'h0, 1'b0);
        check("R2 cond field", 32'(out_cond), 32'h1);
        check("R2 n index", 32'(out_n_idx), 32'd2);
        check("R2 m index", 32'(out_m_idx), 32'd11);
        check("R2 acc index", 32'(out_acc_idx), 32'd10);
        check("R2 dst index", 32'(out_dst_idx), 32'd9);

        // R3 unselected halves have no effect
        run_op(1'b1, 32'hFB11_2304, 32'hFFFF_0003, 32'h8000_0005, 32'h0000_0010, 1'b0);
        check("R3 ignored upper halves", out_result, 32'h0000_001F);

        // R6 sticky, R10 no-match leaves flag, R7 clear and priority
        pulse_clear();
        run_op(1'b1, 32'hFB11_2324, 32'h8000_0000, 32'h0000_8000, 32'h4000_0000, 1'b0);
        check("R6 overflow sets flag", 32'(q_flag), 32'd1);
        run_op(1'b1, 32'hFB11_2304, 32'h0000_0003, 32'h0000_0005, 32'h0000_0010, 1'b0);
        check("R6 flag stays set", 32'(q_flag), 32'd1);
        check("R4 wrapped sum", out_result, 32'h0000_001F);
        run_op(1'b1, 32'hFB11_2344, 32'h0, 32'h0, 32'h0, 1'b0);
        check("R10 no-match keeps flag", 32'(q_flag), 32'd1);
        check("R10 no-match no write", 32'(out_wr_en), 32'd0);
        pulse_clear();
        check("R7 clear lowers flag", 32'(q_flag), 32'd0);
        run_op(1'b1, 32'hFB11_2324, 32'h8000_0000, 32'h0000_8000, 32'h4000_0000, 1'b1);
        check("R7 set wins over clear", 32'(q_flag), 32'd1);

        // R8 unpredictable leaves a set flag alone
        run_op(1'b1, 32'hFB11_2D24, 32'h0, 32'h0, 32'h0, 1'b0);
        check("R8 unpred keeps set flag", 32'(q_flag), 32'd1);
        pulse_clear();

        // R5 multiply-only ignores an accumulator that would overflow
        run_op(1'b1, 32'hFB11_F304, 32'h0000_4000, 32'h0000_4000, 32'h7FFF_FFFF, 1'b0);
        check("R5 product only", out_result, 32'h1000_0000);
        check("R5 no flag", 32'(q_flag), 32'd0);

        // R11 back-to-back and latency
        @(negedge clk);
        in_compact = 1'b1; in_instr = 32'hFB11_2304; in_val_n = 32'h3; in_val_m = 32'h5;
        in_val_acc = 32'h10; in_valid = 1'b1;
        check("R11 no output before edge", 32'(out_valid), 32'd0);
        @(negedge clk);
        in_compact = 1'b0; in_instr = 32'hE101_23C4; in_val_n = 32'hDEAD_0002;
        in_val_m = 32'h0004_BEEF; in_val_acc = 32'hFFFF_FFF0;
        check("R11 first of pair", out_result, 32'h0000_001F);
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 second of pair valid", 32'(out_valid), 32'd1);
        check("R11 second of pair", out_result, 32'hFFFF_FFF8);
        @(negedge clk);
        check("R11 idle after pair", 32'(out_valid), 32'd0);
        check("R11 idle no write", 32'(out_wr_en), 32'd0);

        // R11 reset clears a set flag
        run_op(1'b1, 32'hFB11_2324, 32'h8000_0000, 32'h0000_8000, 32'h4000_0000, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 reset clears flag", 32'(q_flag), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule